// File: doc/BRIEF.md
# Six-Channel Pulse Test Register Bank

This block is the register file of a pulse test design with six channels. It sits on a Wishbone bus as a slave and holds the settings that six pulse generators need: an enable mask, and per channel a start delay, a pulse width and a repetition period, all counted in clock cycles. The settings leave the block on flat configuration buses that feed the generators.

The block also counts pulses. Each channel has an input line from outside and an output line that comes back from its generator. Each line goes through a two-flop synchroniser, and a 32-bit counter counts the line's rising edges. Software reads the twelve counters over the bus. One control bit clears all counters and keeps them at zero for as long as it stays set. The bit does not clear itself. Two read-only words at the bottom of the map identify the design and report its status.

Top module: `chan_regbank`

## Requirements
- R1: A read of byte address 0x000 returns 0x54424C4F.
- R2: A read of byte address 0x004 returns 0x000000FF.
- R3: For channel n (1 to 6), a read of 0x100 + 8·(n−1) returns the number of rising edges seen on pulse_in bit n−1. The count rises by exactly one for each edge.
- R4: For channel n, a read of 0x104 + 8·(n−1) returns the number of rising edges seen on pulse_out bit n−1.
- R5: Address 0x130 holds a clear bit in bit 0, which reads back as written. While the bit is 1, all twelve counters read 0 and edges are not counted. The bit stays set until software writes 0.
- R6: Address 0x200 holds the enable mask. Bit n−1 drives ch_enable bit n−1 for channel n, and 1 means enabled. Bits above bit 5 are not stored and read as 0.
- R7: The delay of channel n is a 32-bit register at 0x204 + 4·(n−1). It drives ch_delay bits [32(n−1)+31 : 32(n−1)].
- R8: The width of channel n is a 32-bit register at 0x21C + 4·(n−1). It drives the same slice of ch_width.
- R9: The period of channel n is a 32-bit register at 0x234 + 4·(n−1). It drives the same slice of ch_period.
- R10: A read of any other address, including one whose two low bits are not zero, returns 0. A write to a read-only or unmapped address changes no register and no output.
- R11: wb_ack rises on the clock edge after a strobe is accepted and stays high for exactly one cycle per access. Read data is valid while wb_ack is high.
- R12: After reset, the enable mask, the clear bit and all delay, width and period registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_cyc | input | 1 | Bus cycle active |
| wb_stb | input | 1 | Strobe |
| wb_we | input | 1 | Write enable |
| wb_adr | input | 12 | Byte address |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack | output | 1 | Access acknowledge |
| pulse_in | input | 6 | External pulse line per channel |
| pulse_out | input | 6 | Generator output line per channel |
| ch_enable | output | 6 | Enable per channel |
| ch_delay | output | 192 | Delay per channel, 32 bits each |
| ch_width | output | 192 | Pulse width per channel, 32 bits each |
| ch_period | output | 192 | Period per channel, 32 bits each |

## Verification
The hardest case to reach is an edge that arrives while the clear bit is held. Such an edge must leave no trace, and the counters can only be seen through bus reads. The bench sets the clear bit and sends pulses on every line while it stays set. It then reads all twelve counters. It clears the bit, sends one more pulse on each line, and checks that each counter now reads exactly 1. Checks on the per-line counts (different counts on different lines) also catch a counter that is wired to the wrong channel or direction.

// File: rtl/chrb_pkg.sv
package chrb_pkg;
  localparam logic [31:0] ID_WORD     = 32'h5442_4C4F;
  localparam logic [31:0] STATUS_WORD = 32'h0000_00FF;
  localparam int ADR_ID     = 'h000;
  localparam int ADR_STATUS = 'h004;
  localparam int CNT_BASE   = 'h100;
  localparam int CFG_BASE   = 'h200;

  // counter word address: channel ch (0-based), outdir selects the output line
  function automatic logic [11:0] cnt_addr(input int ch, input bit outdir);
    return 12'(CNT_BASE + 8 * ch + (outdir ? 4 : 0));
  endfunction

  function automatic logic [11:0] clr_addr(input int nch);
    return 12'(CNT_BASE + 8 * nch);
  endfunction

  function automatic logic [11:0] en_addr();
    return 12'(CFG_BASE);
  endfunction

  function automatic logic [11:0] dly_addr(input int ch);
    return 12'(CFG_BASE + 4 + 4 * ch);
  endfunction

  function automatic logic [11:0] wid_addr(input int ch, input int nch);
    return 12'(CFG_BASE + 4 + 4 * nch + 4 * ch);
  endfunction

  function automatic logic [11:0] per_addr(input int ch, input int nch);
    return 12'(CFG_BASE + 4 + 8 * nch + 4 * ch);
  endfunction
endpackage

// File: rtl/chrb_edge_counter.sv
module chrb_edge_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             pulse,
  output logic [CNT_W-1:0] count
);
  logic [2:0] sync_q;
  logic       rise;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], pulse};
  end

  assign rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (rise) count <= count + CNT_W'(1);
  end

  a_r5_clear_forces_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
  a_r3_step_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count == $past(count) || count == $past(count) + CNT_W'(1)));
  a_r3_edge_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !clr) |=> (count != $past(count)));
endmodule

// File: rtl/chrb_cfg_bank.sv
module chrb_cfg_bank
  import chrb_pkg::*;
#(
  parameter int NCH = 6,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [11:0]       adr,
  input  logic [DW-1:0]     wr_dat,
  output logic [NCH-1:0]    enable,
  output logic              clr,
  output logic [NCH*DW-1:0] delay,
  output logic [NCH*DW-1:0] width,
  output logic [NCH*DW-1:0] period,
  output logic              cfg_hit,
  output logic [DW-1:0]     cfg_rdata
);
  logic en_wr, clr_wr;

  assign en_wr  = wr_en && (adr == en_addr());
  assign clr_wr = wr_en && (adr == clr_addr(NCH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable <= '0;
      clr    <= 1'b0;
    end else begin
      if (en_wr)  enable <= wr_dat[NCH-1:0];
      if (clr_wr) clr    <= wr_dat[0];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        delay[c*DW +: DW]  <= '0;
        width[c*DW +: DW]  <= '0;
        period[c*DW +: DW] <= '0;
      end else if (wr_en) begin
        if (adr == dly_addr(c))      delay[c*DW +: DW]  <= wr_dat;
        if (adr == wid_addr(c, NCH)) width[c*DW +: DW]  <= wr_dat;
        if (adr == per_addr(c, NCH)) period[c*DW +: DW] <= wr_dat;
      end
    end
  end

  always_comb begin
    cfg_hit   = 1'b0;
    cfg_rdata = '0;
    if (adr == en_addr()) begin
      cfg_hit   = 1'b1;
      cfg_rdata = DW'(enable);
    end
    if (adr == clr_addr(NCH)) begin
      cfg_hit   = 1'b1;
      cfg_rdata = DW'(clr);
    end
    for (int c = 0; c < NCH; c++) begin
      if (adr == dly_addr(c)) begin
        cfg_hit = 1'b1; cfg_rdata = delay[c*DW +: DW];
      end
      if (adr == wid_addr(c, NCH)) begin
        cfg_hit = 1'b1; cfg_rdata = width[c*DW +: DW];
      end
      if (adr == per_addr(c, NCH)) begin
        cfg_hit = 1'b1; cfg_rdata = period[c*DW +: DW];
      end
    end
  end

  a_r6_enable_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(enable));
  a_r5_clear_not_self_clearing: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(clr));
  a_r9_period_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(period));
endmodule

// File: rtl/chan_regbank.sv
module chan_regbank
  import chrb_pkg::*;
#(
  parameter int NCH = 6,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_cyc,
  input  logic              wb_stb,
  input  logic              wb_we,
  input  logic [11:0]       wb_adr,
  input  logic [DW-1:0]     wb_dat_i,
  output logic [DW-1:0]     wb_dat_o,
  output logic              wb_ack,
  input  logic [NCH-1:0]    pulse_in,
  input  logic [NCH-1:0]    pulse_out,
  output logic [NCH-1:0]    ch_enable,
  output logic [NCH*DW-1:0] ch_delay,
  output logic [NCH*DW-1:0] ch_width,
  output logic [NCH*DW-1:0] ch_period
);
  localparam int NCNT = 2 * NCH;

  logic              accept, wr_en, cnt_clr;
  logic              cfg_hit, rd_hit;
  logic [DW-1:0]     cfg_rdata, rdata;
  logic [NCNT*DW-1:0] counts;

  assign accept = wb_cyc && wb_stb && !wb_ack;
  assign wr_en  = accept && wb_we;

  chrb_cfg_bank #(.NCH(NCH), .DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .adr(wb_adr), .wr_dat(wb_dat_i),
    .enable(ch_enable), .clr(cnt_clr), .delay(ch_delay), .width(ch_width),
    .period(ch_period), .cfg_hit(cfg_hit), .cfg_rdata(cfg_rdata)
  );

  // counter k: channel k/2, even k counts the input line, odd k the output line
  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    chrb_edge_counter #(.CNT_W(DW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr),
      .pulse((k % 2 == 0) ? pulse_in[k/2] : pulse_out[k/2]),
      .count(counts[k*DW +: DW])
    );
  end

  always_comb begin
    rd_hit = cfg_hit;
    rdata  = cfg_rdata;
    if (wb_adr == 12'(ADR_ID)) begin
      rd_hit = 1'b1; rdata = ID_WORD;
    end
    if (wb_adr == 12'(ADR_STATUS)) begin
      rd_hit = 1'b1; rdata = STATUS_WORD;
    end
    for (int k = 0; k < NCNT; k++) begin
      if (wb_adr == cnt_addr(k / 2, (k % 2) == 1)) begin
        rd_hit = 1'b1; rdata = counts[k*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_ack   <= 1'b0;
      wb_dat_o <= '0;
    end else begin
      wb_ack   <= accept;
      wb_dat_o <= (accept && !wb_we && rd_hit) ? rdata : '0;
    end
  end

  a_r11_ack_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ack |=> !wb_ack);
  a_r11_ack_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> wb_ack);
  a_r10_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !wb_we && !rd_hit) |=> (wb_dat_o == '0));
  a_r1_id_word: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !wb_we && wb_adr == 12'(ADR_ID)) |=> (wb_dat_o == ID_WORD));
endmodule

// File: tb/sim_chan_regbank.sv
module sim_chan_regbank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wb_cyc = 0, wb_stb = 0, wb_we = 0;
  logic [11:0] wb_adr = '0;
  logic [31:0] wb_dat_i = '0;
  logic [31:0] wb_dat_o;
  logic wb_ack;
  logic [5:0] pulse_in = '0, pulse_out = '0;
  logic [5:0] ch_enable;
  logic [191:0] ch_delay, ch_width, ch_period;

  int checks = 0, fails = 0;
  bit done = 0, live = 0;

  // reference model state
  logic [5:0]  m_en = '0;
  logic        m_clr = 0;
  logic [31:0] m_dly[6], m_wid[6], m_per[6];
  int unsigned m_cin[6], m_cout[6];

  always #2 clk = ~clk;

  chan_regbank u0 (
    .clk(clk), .rst_n(rst_n), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_adr(wb_adr), .wb_dat_i(wb_dat_i), .wb_dat_o(wb_dat_o), .wb_ack(wb_ack),
    .pulse_in(pulse_in), .pulse_out(pulse_out), .ch_enable(ch_enable),
    .ch_delay(ch_delay), .ch_width(ch_width), .ch_period(ch_period)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input int a);
    if (a == 0) return 32'h5442_4C4F;
    if (a == 4) return 32'hFF;
    if (a == 'h130) return {31'b0, m_clr};
    if (a == 'h200) return {26'b0, m_en};
    if (a % 4 != 0) return 0;
    if (a >= 'h100 && a < 'h130)
      return ((a - 'h100) % 8 == 0) ? m_cin[(a - 'h100) / 8] : m_cout[(a - 'h100) / 8];
    if (a >= 'h204 && a < 'h21C) return m_dly[(a - 'h204) / 4];
    if (a >= 'h21C && a < 'h234) return m_wid[(a - 'h21C) / 4];
    if (a >= 'h234 && a < 'h24C) return m_per[(a - 'h234) / 4];
    return 0;
  endfunction

  function automatic void model_write(input int a, input logic [31:0] d);
    if (a % 4 != 0) return;
    if (a == 'h200) m_en = d[5:0];
    if (a == 'h130) begin
      m_clr = d[0];
      if (d[0]) for (int i = 0; i < 6; i++) begin m_cin[i] = 0; m_cout[i] = 0; end
    end
    if (a >= 'h204 && a < 'h21C) m_dly[(a - 'h204) / 4] = d;
    if (a >= 'h21C && a < 'h234) m_wid[(a - 'h21C) / 4] = d;
    if (a >= 'h234 && a < 'h24C) m_per[(a - 'h234) / 4] = d;
  endfunction

  // R11: one access, ack expected on the next edge only
  task automatic bus(input bit we, input int a, input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = we; wb_adr = 12'(a); wb_dat_i = d;
    @(negedge clk);
    check("R11 ack after strobe", {31'b0, wb_ack}, 32'd1);
    rd = wb_dat_o;
    if (we) model_write(a, d);
    wb_cyc = 0; wb_stb = 0; wb_we = 0;
    @(negedge clk);
    check("R11 ack single cycle", {31'b0, wb_ack}, 32'd0);
  endtask

  task automatic rd_check(input string tag, input int a);
    logic [31:0] v;
    bus(0, a, 0, v);
    check(tag, v, model_read(a));
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    logic [31:0] v;
    bus(1, a, d, v);
  endtask

  task automatic pulse(input logic [5:0] im, input logic [5:0] om);
    @(negedge clk);
    pulse_in = im; pulse_out = om;
    repeat (3) @(negedge clk);
    pulse_in = '0; pulse_out = '0;
    repeat (3) @(negedge clk);
    if (!m_clr) for (int i = 0; i < 6; i++) begin
      if (im[i]) m_cin[i]++;
      if (om[i]) m_cout[i]++;
    end
  endtask

  // per-clock comparison of the configuration outputs (R6..R9, R12 after reset)
  always @(negedge clk) begin
    #1;
    if (live) begin
      check("R6/R12 enable", {26'b0, ch_enable}, {26'b0, m_en});
      for (int i = 0; i < 6; i++) begin
        check("R7/R12 delay", ch_delay[32*i +: 32], m_dly[i]);
        check("R8/R12 width", ch_width[32*i +: 32], m_wid[i]);
        check("R9/R12 period", ch_period[32*i +: 32], m_per[i]);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) begin
      m_dly[i] = 0; m_wid[i] = 0; m_per[i] = 0; m_cin[i] = 0; m_cout[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    live = 1;
    @(negedge clk);
    // R12 reset values via the bus
    rd_check("R12 enable reset", 'h200);
    rd_check("R12 clear reset", 'h130);
    rd_check("R12 delay reset", 'h204);
    rd_check("R12 period reset", 'h248);
    // R1 R2
    rd_check("R1 id word", 'h000);
    rd_check("R2 status word", 'h004);
    // R7 R8 R9 R6: distinct values everywhere
    for (int c = 0; c < 6; c++) begin
      wr('h204 + 4*c, 32'hD000_0000 + c * 32'h111);
      wr('h21C + 4*c, 32'h0A00_0000 + c * 32'h2003);
      wr('h234 + 4*c, 32'hF00F_0000 + c * 32'h40001);
    end
    wr('h200, 32'hFFFF_FFE5);
    rd_check("R6 enable upper bits dropped", 'h200);
    for (int c = 0; c < 6; c++) begin
      rd_check("R7 delay readback", 'h204 + 4*c);
      rd_check("R8 width readback", 'h21C + 4*c);
      rd_check("R9 period readback", 'h234 + 4*c);
    end
    // R10: unmapped reads and ignored writes
    rd_check("R10 unmapped 0x008", 'h008);
    rd_check("R10 unmapped 0x134", 'h134);
    rd_check("R10 unmapped 0x24C", 'h24C);
    rd_check("R10 unmapped 0x300", 'h300);
    rd_check("R10 misaligned 0x206", 'h206);
    wr('h000, 32'h1234_5678);
    wr('h104, 32'hFFFF_FFFF);
    wr('h24C, 32'hAAAA_AAAA);
    wr('h206, 32'h5555_5555);
    rd_check("R10 id after write", 'h000);
    rd_check("R10 counter after write", 'h104);
    rd_check("R10 delay after misaligned write", 'h204);
    // R3 R4: different counts per line
    for (int p = 0; p < 8; p++) begin
      logic [5:0] im, om;
      for (int i = 0; i < 6; i++) begin
        im[i] = (p <= i);
        om[i] = (p <= i + 2);
      end
      pulse(im, om);
    end
    for (int c = 0; c < 6; c++) begin
      rd_check("R3 input count", 'h100 + 8*c);
      rd_check("R4 output count", 'h104 + 8*c);
    end
    // R5: hold clear, pulse, release, pulse once
    wr('h130, 32'h1);
    rd_check("R5 clear readback", 'h130);
    rd_check("R5 counter zero under clear", 'h100);
    repeat (3) pulse(6'h3F, 6'h3F);
    rd_check("R5 clear still set", 'h130);
    for (int c = 0; c < 6; c++) begin
      rd_check("R5 input held zero", 'h100 + 8*c);
      rd_check("R5 output held zero", 'h104 + 8*c);
    end
    wr('h130, 32'h0);
    pulse(6'h3F, 6'h3F);
    for (int c = 0; c < 6; c++) begin
      rd_check("R5 input counts after release", 'h100 + 8*c);
      rd_check("R5 output counts after release", 'h104 + 8*c);
    end
    wr('h200, 32'h0);
    rd_check("R6 enable cleared", 'h200);
    repeat (4) @(negedge clk);
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule